// File: doc/BRIEF.md
# Serial Character Transmitter with Holding Stage

This block turns characters written by a processor into an asynchronous serial bit stream. A character is written into a holding register. The transmitter moves it into a separate shift register when it begins a frame, so the next character can be written while the current one is still going out. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. The stop period can last one bit, one and a half bits or two bits. A break input holds the line low for as long as it is asserted.

Timing comes from a one-cycle tick pulse that runs at 16 times the bit rate. A frame only ever begins on a tick. Each bit lasts a fixed number of ticks, set by a parameter.

Two status flags report progress. One shows that the holding register is free. The other shows that the holding register and the shift register are both empty, so the line is idle.

Top module: `uart_tx_hold`

## Requirements
- R1: While reset is held and after it is released, `txd_o` is 1 and both `thr_empty_o` and `tx_empty_o` are 1.
- R2: A write sampled on clock edge E0 leaves both status flags unchanged just after E0. Both flags are 0 just after the next edge, E1.
- R3: The start bit of the written character begins on the first `tick_i` sampled at E2 or later, where E2 is the edge after E1. It never begins on a cycle without a tick.
- R4: A frame is a start bit of 0 followed by the data bits, least significant bit first. Each bit lasts 16 ticks. `len_code_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper data bits are not sent.
- R5: When `par_en_i` is 1, one parity bit follows the data bits. With `par_odd_i` = 0 it is the XOR of the data bits sent. With `par_odd_i` = 1 it is the inverse of that XOR.
- R6: The stop period is high. With `stop_long_i` = 0 it lasts 16 ticks. With `stop_long_i` = 1 it lasts 24 ticks for 5-bit characters and 32 ticks for all other lengths.
- R7: `thr_empty_o` returns to 1 on the tick that moves the character into the shift register. `tx_empty_o` returns to 1 on the last stop tick when no character is waiting. `tx_empty_o` = 1 always implies `thr_empty_o` = 1.
- R8: If a character is already waiting when the stop period ends, its start bit begins on the tick that ends the stop period, with no idle gap.
- R9: `brk_i` = 1 drives `txd_o` to 0 in the same cycle, whether the line is idle or a frame is being sent. It does not start a frame and does not change the frame timing.
- R10: The line settings (`len_code_i`, `par_en_i`, `par_odd_i`, `stop_long_i`) are captured when a frame starts. Changing them during the frame has no effect on it.
- R11: When no frame is in progress and `brk_i` = 0, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thr_wr_i | input | 1 | Holding-register write strobe |
| thr_data_i | input | 8 | Character to write |
| len_code_i | input | 2 | Data-bit count code (0..3 selects 5..8 bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Selects odd parity |
| stop_long_i | input | 1 | Selects the long stop period (1.5 or 2 bits) |
| brk_i | input | 1 | Forces the line low |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| txd_o | output | 1 | Serial output, high when idle |
| thr_empty_o | output | 1 | Holding register is free |
| tx_empty_o | output | 1 | Holding and shift registers are both empty |

## Verification
Assertions check the following on every cycle:
- the two-edge clearing of the flags after a write;
- that a frame leaves idle only on a tick;
- that the transmitter-empty flag implies the holding-empty flag;
- that the line is high whenever the transmitter reports empty and no break is applied;
- that the captured settings stay fixed between frame starts.

Some behaviours can only be shown by the bench's scenarios:
- bit order and parity values;
- the exact tick counts of each stop length;
- back-to-back chaining with no gap;
- immunity to settings changed in mid-frame;
- break during a frame.

The bench decodes the line at mid-bit and times the flags to check these.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int unsigned LEN_CODE_W    = 2;
   localparam int unsigned MIN_CHAR_BITS = 5;
   localparam int unsigned MAX_CHAR_BITS = MIN_CHAR_BITS + (1 << LEN_CODE_W) - 1;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } tx_phase_e;

   typedef struct packed {
      logic [LEN_CODE_W-1:0] len_code;
      logic                  par_en;
      logic                  par_odd;
      logic                  stop_long;
   } line_cfg_t;

   // Parity over the bits that will actually be sent, inverted for odd.
   function automatic logic char_parity(input logic [MAX_CHAR_BITS-1:0] d,
                                        input logic [LEN_CODE_W-1:0]    len_code,
                                        input logic                     odd);
      logic acc;
      acc = odd;
      for (int i = 0; i < int'(MAX_CHAR_BITS); i++) begin
         if (i < int'(MIN_CHAR_BITS) + int'(len_code)) acc = acc ^ d[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/uart_tx_holding.sv
module uart_tx_holding
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = MAX_CHAR_BITS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              take_i,
   input  logic              frame_done_i,
   output logic [DATA_W-1:0] hold_data_o,
   output logic              hold_ready_o,
   output logic              thr_empty_o,
   output logic              tx_empty_o
);

   logic              arm_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              thr_empty_q;
   logic              tx_empty_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q       <= 1'b0;
         valid_q     <= 1'b0;
         data_q      <= '0;
         thr_empty_q <= 1'b1;
         tx_empty_q  <= 1'b1;
      end else begin
         arm_q <= wr_i;
         if (wr_i) data_q <= data_i;

         if (arm_q)       valid_q <= 1'b1;
         else if (take_i) valid_q <= 1'b0;

         if (arm_q)       thr_empty_q <= 1'b0;
         else if (take_i) thr_empty_q <= 1'b1;

         if (arm_q)                          tx_empty_q <= 1'b0;
         else if (frame_done_i && !valid_q)  tx_empty_q <= 1'b1;
      end
   end

   // A character becomes eligible only after its arming stage has passed.
   assign hold_ready_o = valid_q & ~arm_q;
   assign hold_data_o  = data_q;
   assign thr_empty_o  = thr_empty_q;
   assign tx_empty_o   = tx_empty_q;

   AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |-> ##2 (!thr_empty_o && !tx_empty_o)); // R2

   AST_TAKE_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> (valid_q && !thr_empty_o)); // R7

endmodule

// File: rtl/uart_tx_frame_cfg.sv
module uart_tx_frame_cfg
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVS          = 16,
   parameter bit          HALF_STOP_EN = 1'b1,
   localparam int unsigned CNT_W       = $clog2(2 * OVS),
   localparam int unsigned IDX_W       = $clog2(MAX_CHAR_BITS)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     load_i,
   input  line_cfg_t                cfg_i,
   input  logic [MAX_CHAR_BITS-1:0] data_i,
   output logic [IDX_W-1:0]         last_bit_o,
   output logic                     par_en_o,
   output logic                     par_bit_o,
   output logic [CNT_W-1:0]         stop_last_o
);

   localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'((OVS * 3) / 2 - 1);
   localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVS - 1);

   line_cfg_t cfg_q;
   logic      par_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
         par_q <= 1'b0;
      end else if (load_i) begin
         cfg_q <= cfg_i;
         par_q <= char_parity(data_i, cfg_i.len_code, cfg_i.par_odd);
      end
   end

   assign last_bit_o = IDX_W'(MIN_CHAR_BITS - 1) + IDX_W'(cfg_q.len_code);
   assign par_en_o   = cfg_q.par_en;
   assign par_bit_o  = par_q;

   generate
      if (HALF_STOP_EN) begin : g_half_stop
         always_comb begin
            if (!cfg_q.stop_long)       stop_last_o = STOP_ONE;
            else if (cfg_q.len_code == '0) stop_last_o = STOP_HALF;
            else                        stop_last_o = STOP_TWO;
         end
      end else begin : g_whole_stop
         assign stop_last_o = cfg_q.stop_long ? STOP_TWO : STOP_ONE;
      end
   endgenerate

   AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ($stable(cfg_q) && $stable(par_q))); // R10

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   localparam int unsigned CNT_W = $clog2(2 * OVS),
   localparam int unsigned IDX_W = $clog2(MAX_CHAR_BITS)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     tick_i,
   input  logic                     hold_ready_i,
   input  logic [MAX_CHAR_BITS-1:0] hold_data_i,
   input  logic [IDX_W-1:0]         last_bit_i,
   input  logic                     par_en_i,
   input  logic                     par_bit_i,
   input  logic [CNT_W-1:0]         stop_last_i,
   output logic                     take_o,
   output logic                     frame_done_o,
   output logic                     line_o
);

   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

   tx_phase_e                phase_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [IDX_W-1:0]         idx_q;
   logic [MAX_CHAR_BITS-1:0] shift_q;
   logic                     bit_end;
   logic                     stop_end;

   assign bit_end      = (cnt_q == BIT_LAST);
   assign stop_end     = (phase_q == PH_STOP) && (cnt_q == stop_last_i);
   assign take_o       = tick_i & hold_ready_i & ((phase_q == PH_IDLE) | stop_end);
   assign frame_done_o = tick_i & stop_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
      end else if (take_o) begin
         phase_q <= PH_START;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= hold_data_i;
      end else if (tick_i) begin
         unique case (phase_q)
            PH_START: begin
               if (bit_end) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + CNT_W'(1);
            end
            PH_DATA: begin
               if (bit_end) begin
                  cnt_q <= '0;
                  if (idx_q == last_bit_i) begin
                     phase_q <= par_en_i ? PH_PARITY : PH_STOP;
                  end else begin
                     idx_q   <= idx_q + IDX_W'(1);
                     shift_q <= shift_q >> 1;
                  end
               end else cnt_q <= cnt_q + CNT_W'(1);
            end
            PH_PARITY: begin
               if (bit_end) begin
                  phase_q <= PH_STOP;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + CNT_W'(1);
            end
            PH_STOP: begin
               if (stop_end) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_START:  line_o = 1'b0;
         PH_DATA:   line_o = shift_q[0];
         PH_PARITY: line_o = par_bit_i;
         default:   line_o = 1'b1;
      endcase
   end

   AST_LEAVE_IDLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_IDLE && !tick_i) |=> (phase_q == PH_IDLE)); // R3

   AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(line_o)); // R4

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVS          = 16,
   parameter bit          HALF_STOP_EN = 1'b1,
   localparam int unsigned CNT_W       = $clog2(2 * OVS),
   localparam int unsigned IDX_W       = $clog2(MAX_CHAR_BITS)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     thr_wr_i,
   input  logic [MAX_CHAR_BITS-1:0] thr_data_i,
   input  logic [LEN_CODE_W-1:0]    len_code_i,
   input  logic                     par_en_i,
   input  logic                     par_odd_i,
   input  logic                     stop_long_i,
   input  logic                     brk_i,
   input  logic                     tick_i,
   output logic                     txd_o,
   output logic                     thr_empty_o,
   output logic                     tx_empty_o
);

   initial begin
      AST_OVS_EVEN: assert (OVS >= 2 && (OVS % 2) == 0)
         else $error("OVS must be an even value of at least 2"); // R6
   end

   logic [MAX_CHAR_BITS-1:0] hold_data;
   logic                     hold_ready;
   logic                     take;
   logic                     frame_done;
   logic [IDX_W-1:0]         last_bit;
   logic                     par_en;
   logic                     par_bit;
   logic [CNT_W-1:0]         stop_last;
   logic                     line;
   line_cfg_t                cfg_in;

   assign cfg_in = '{len_code: len_code_i, par_en: par_en_i,
                     par_odd: par_odd_i, stop_long: stop_long_i};

   uart_tx_holding #(.DATA_W(MAX_CHAR_BITS)) u_holding (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (thr_wr_i),
      .data_i       (thr_data_i),
      .take_i       (take),
      .frame_done_i (frame_done),
      .hold_data_o  (hold_data),
      .hold_ready_o (hold_ready),
      .thr_empty_o  (thr_empty_o),
      .tx_empty_o   (tx_empty_o)
   );

   uart_tx_frame_cfg #(.OVS(OVS), .HALF_STOP_EN(HALF_STOP_EN)) u_frame_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (take),
      .cfg_i       (cfg_in),
      .data_i      (hold_data),
      .last_bit_o  (last_bit),
      .par_en_o    (par_en),
      .par_bit_o   (par_bit),
      .stop_last_o (stop_last)
   );

   uart_tx_serializer #(.OVS(OVS)) u_serializer (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .hold_ready_i (hold_ready),
      .hold_data_i  (hold_data),
      .last_bit_i   (last_bit),
      .par_en_i     (par_en),
      .par_bit_i    (par_bit),
      .stop_last_i  (stop_last),
      .take_o       (take),
      .frame_done_o (frame_done),
      .line_o       (line)
   );

   assign txd_o = line & ~brk_i;

   AST_EMPTY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_empty_o |-> thr_empty_o); // R7

   AST_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_empty_o && !brk_i) |-> txd_o); // R11

endmodule

// File: tb/uart_tx_hold_bench.sv
module uart_tx_hold_bench;
   import uart_tx_pkg::*;

   localparam int TICK_PER = 4;
   localparam int BIT_CLK  = 16 * TICK_PER;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [1:0] len_code = '0;
   logic       par_en = 1'b0, par_odd = 1'b0, stop_long = 1'b0, brk = 1'b0;
   logic       tick = 1'b0;
   logic       txd, thr_empty, tx_empty;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_tx_hold u_uart_tx_hold (
      .clk_i(clk), .rst_ni(rst_n), .thr_wr_i(wr), .thr_data_i(wdata),
      .len_code_i(len_code), .par_en_i(par_en), .par_odd_i(par_odd),
      .stop_long_i(stop_long), .brk_i(brk), .tick_i(tick),
      .txd_o(txd), .thr_empty_o(thr_empty), .tx_empty_o(tx_empty)
   );

   initial begin
      forever begin
         repeat (TICK_PER - 1) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic exp_par(input logic [7:0] d, input logic [1:0] lc, input logic odd);
      logic p;
      p = odd;
      for (int i = 0; i < 5 + int'(lc); i++) p = p ^ d[i];
      return p;
   endfunction

   function automatic int frame_ticks(input logic [1:0] lc, input logic pe, input logic sl);
      int st;
      st = !sl ? 16 : (lc == 2'd0 ? 24 : 32);
      return 16 * (1 + 5 + int'(lc) + int'(pe)) + st;
   endfunction

   task automatic wait_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic wait_idle();
      int g = 0;
      while (tx_empty !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
   endtask

   task automatic put_char(input logic [7:0] d, output int w);
      @(negedge clk);
      wr = 1'b1; wdata = d;
      @(negedge clk);
      wr = 1'b0;
      w = cyc;
   endtask

   task automatic watch_frame(input logic [7:0] d, input logic [1:0] lc, input logic pe,
                              input logic po, input bit scramble, output int f);
      int g = 0;
      int k;
      while (txd !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
      f = cyc;
      if (scramble) begin
         len_code = ~lc; par_en = ~pe; par_odd = ~po; stop_long = ~stop_long;
      end
      wait_to(f + BIT_CLK / 2);
      chk(txd === 1'b0, "R4 start bit low", int'(txd), 0);
      chk(thr_empty === 1'b1, "R7 holding empty after start", int'(thr_empty), 1);
      for (int i = 0; i < 5 + int'(lc); i++) begin
         wait_to(f + BIT_CLK / 2 + BIT_CLK * (i + 1));
         chk(txd === d[i], scramble ? "R10 data bit under changed settings" : "R4 data bit",
             int'(txd), int'(d[i]));
      end
      k = 6 + int'(lc);
      if (pe) begin
         wait_to(f + BIT_CLK / 2 + BIT_CLK * k);
         chk(txd === exp_par(d, lc, po), "R5 parity bit", int'(txd), int'(exp_par(d, lc, po)));
         k++;
      end
      wait_to(f + BIT_CLK / 2 + BIT_CLK * k);
      chk(txd === 1'b1, "R6 stop level", int'(txd), 1);
   endtask

   task automatic send_checked(input logic [7:0] d, input logic [1:0] lc, input logic pe,
                               input logic po, input logic sl, input bit scramble);
      int w, f, g;
      wait_idle();
      @(negedge clk);
      len_code = lc; par_en = pe; par_odd = po; stop_long = sl;
      put_char(d, w);
      chk(thr_empty === 1'b1 && tx_empty === 1'b1, "R2 flags unchanged after first edge",
          int'({thr_empty, tx_empty}), 3);
      @(negedge clk);
      chk(thr_empty === 1'b0 && tx_empty === 1'b0, "R2 flags cleared after second edge",
          int'({thr_empty, tx_empty}), 0);
      watch_frame(d, lc, pe, po, scramble, f);
      chk(f - w >= 2 && f - w <= 1 + TICK_PER, "R3 start latency", f - w, 2);
      g = 0;
      while (tx_empty !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      chk(cyc - f == TICK_PER * frame_ticks(lc, pe, sl), "R6 frame length to empty",
          cyc - f, TICK_PER * frame_ticks(lc, pe, sl));
      chk(thr_empty === 1'b1, "R7 both empty at end", int'(thr_empty), 1);
   endtask

   initial begin
      int fa, fb, w, g;
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      chk(txd === 1'b1 && thr_empty === 1'b1 && tx_empty === 1'b1, "R1 reset state",
          int'({txd, thr_empty, tx_empty}), 7);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(txd === 1'b1 && thr_empty === 1'b1 && tx_empty === 1'b1, "R1 after release",
          int'({txd, thr_empty, tx_empty}), 7);
      chk(txd === 1'b1, "R11 idle line high", int'(txd), 1);

      // Directed corners
      send_checked(8'h00, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
      send_checked(8'hFF, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
      send_checked(8'hA5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
      send_checked(8'h3C, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1);

      // R8 back-to-back chaining
      wait_idle();
      @(negedge clk);
      len_code = 2'd3; par_en = 1'b1; par_odd = 1'b0; stop_long = 1'b0;
      put_char(8'h96, w);
      watch_frame(8'h96, 2'd3, 1'b1, 1'b0, 1'b0, fa);
      put_char(8'h5A, w);
      chk(tx_empty === 1'b0, "R8 busy while second char waits", int'(tx_empty), 0);
      watch_frame(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0, fb);
      chk(fb - fa == TICK_PER * frame_ticks(2'd3, 1'b1, 1'b0), "R8 no gap between frames",
          fb - fa, TICK_PER * frame_ticks(2'd3, 1'b1, 1'b0));

      // R9 break while idle and during a frame
      wait_idle();
      @(negedge clk);
      brk = 1'b1;
      #2;
      chk(txd === 1'b0, "R9 break forces low when idle", int'(txd), 0);
      repeat (20) @(negedge clk);
      chk(tx_empty === 1'b1 && txd === 1'b0, "R9 break starts no frame",
          int'({tx_empty, txd}), 2);
      brk = 1'b0;
      #2;
      chk(txd === 1'b1, "R11 line high after break release", int'(txd), 1);
      len_code = 2'd3; par_en = 1'b0; stop_long = 1'b0;
      put_char(8'hFF, w);
      g = 0;
      while (txd !== 1'b0 && g < 100) begin @(negedge clk); g++; end
      fa = cyc;
      wait_to(fa + BIT_CLK * 3);
      chk(txd === 1'b1, "R9 data bit high before break", int'(txd), 1);
      brk = 1'b1;
      #2;
      chk(txd === 1'b0, "R9 break forces low mid frame", int'(txd), 0);
      @(negedge clk);
      brk = 1'b0;
      g = 0;
      while (tx_empty !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      chk(cyc - fa == TICK_PER * frame_ticks(2'd3, 1'b0, 1'b0), "R9 timing kept through break",
          cyc - fa, TICK_PER * frame_ticks(2'd3, 1'b0, 1'b0));

      // Constrained random frames, some with settings changed mid-frame
      for (int i = 0; i < 36; i++) begin
         send_checked(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), (i % 4) == 1);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule